// File: doc/BRIEF.md
# Two-Cell Shunt Balancing Controller

This block decides, once per balancing pass, whether one of two series-connected battery cells should have its bypass shunt closed and which cell that is. It waits a programmable number of one-second ticks between passes. A pass opens by asking the charger to pause and by opening both shunts. After a settling delay it captures both cell voltage codes together with the charge current, the phase flag and the constant-voltage flag. It then computes the higher and lower cell code and their spread, and applies the rule for the current phase.

In the charge phase the pause is lifted as soon as the decision is made. A shunt is closed when the spread is above the charge threshold, except while the charger regulates voltage and the current is under the minimum balancing current. In the discharge phase the spread must exceed the discharge threshold and the higher cell must be at or above a mid-charge level. The pause stays asserted until the pass ends. The chosen shunt stays closed for an end delay. A one-cycle status strobe marks the decision. A clear input from the supervising charger opens both shunts and restarts the interval.

States: `ST_IDLE` (count interval) -> `ST_SETTLE` (pause, shunts open, count start delay) -> `ST_EVAL` (captured values present) -> `ST_REPORT` (shunt applied, strobe) -> `ST_HOLD` (count end delay) -> `ST_IDLE`. From any state, a clear returns the machine to `ST_IDLE`.

Top module: `cell_balance_ctrl`

## Requirements
- R1: After reset both shunts, the pause request and the strobe are low, and the controller waits in the idle state.
- R2: After `interval_s` ticks in idle, `chg_pause` rises with both shunts low; before the last of those ticks `chg_pause` stays low.
- R3: Cell values are captured on the tick that completes `start_dly_s`; in the cycle after it `chg_pause` is still high and no strobe has been given.
- R4: In the discharge phase (`dis_phase`=1) a shunt closes only when max-min > `thr_discharge` and max >= `mid_level`.
- R5: In the charge phase (`dis_phase`=0) a shunt closes when max-min > `thr_charge`, unless `cv_mode`=1 and `chg_cur_code` < `min_bal_cur`.
- R6: A closing shunt goes to cell A when cell A's code is strictly greater than cell B's; otherwise it goes to cell B.
- R7: In the charge phase `chg_pause` falls in the cycle the decision is reported; in the discharge phase it stays high until the pass ends.
- R8: `report_stb` is high for exactly one cycle per pass, the first cycle in which the decided shunt is driven.
- R9: The decided shunt stays driven until the tick that completes `end_dly_s`; after it both shunts and `chg_pause` are low.
- R10: `sup_clear` high on a clock edge makes both shunts and `chg_pause` low from that edge, and the interval count restarts.
- R11: `shunt_a` and `shunt_b` are never high together.
- R12: A delay or interval value of zero acts as one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sup_clear | input | 1 | Clear from the supervising charger |
| tick_1hz | input | 1 | One-cycle pulse per second |
| cell_a_code | input | CW | Cell A voltage code |
| cell_b_code | input | CW | Cell B voltage code |
| chg_cur_code | input | CW | Charge current code |
| dis_phase | input | 1 | 1 = discharge phase, 0 = charge phase |
| cv_mode | input | 1 | Charger in constant-voltage regulation |
| thr_charge | input | CW | Spread threshold, charge phase |
| thr_discharge | input | CW | Spread threshold, discharge phase |
| mid_level | input | CW | Mid-charge voltage code |
| min_bal_cur | input | CW | Minimum current for balancing in constant-voltage mode |
| interval_s | input | TW | Ticks between passes |
| start_dly_s | input | TW | Settling ticks before capture |
| end_dly_s | input | TW | Ticks the shunt is held |
| shunt_a | output | 1 | Shunt enable for cell A |
| shunt_b | output | 1 | Shunt enable for cell B |
| chg_pause | output | 1 | Request to stop charging |
| report_stb | output | 1 | One-cycle decision strobe |

## Verification
The hardest situation to reach is a decision exactly at a boundary. Examples are a spread equal to the threshold, a higher cell exactly at the mid-charge level, and a current exactly at the minimum under constant-voltage mode. Each must fall on the right side only through the captured values. Random passes build cell B as cell A plus or minus a small offset, so the spread keeps straddling the thresholds. Directed passes pin each boundary value exactly. One directed pass raises the clear during the hold phase, to show that a closed shunt opens at once and that the next pass again waits a full interval.

// File: rtl/cbal_pkg.sv
package cbal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_EVAL   = 3'd2,
        ST_REPORT = 3'd3,
        ST_HOLD   = 3'd4
    } cbal_state_t;

    typedef struct packed {
        logic dis;
        logic cv;
    } cbal_mode_t;

endpackage

// File: rtl/cbal_tick_timer.sv
module cbal_tick_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

    logic [TW-1:0] cnt_q;
    logic [TW:0]   cnt_next_w;

    assign cnt_next_w = {1'b0, cnt_q} + {{TW{1'b0}}, 1'b1};
    // a limit of zero is met on the first tick, like a limit of one
    assign expire = en && tick && (cnt_next_w >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (en && tick && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cbal_spread.sv
module cbal_spread #(
    parameter int CW = 12
) (
    input  logic [CW-1:0] code_a,
    input  logic [CW-1:0] code_b,
    output logic [CW-1:0] hi,
    output logic [CW-1:0] spread,
    output logic          a_above
);
    logic [CW-1:0] lo;

    always_comb begin
        a_above = (code_a > code_b);
        if (a_above) begin
            hi = code_a;
            lo = code_b;
        end else begin
            hi = code_b;
            lo = code_a;
        end
        spread = hi - lo;
    end

endmodule

// File: rtl/cbal_judge.sv
module cbal_judge #(
    parameter int CW = 12
) (
    input  cbal_pkg::cbal_mode_t mode,
    input  logic [CW-1:0] hi,
    input  logic [CW-1:0] spread,
    input  logic [CW-1:0] cur,
    input  logic [CW-1:0] thr_charge,
    input  logic [CW-1:0] thr_discharge,
    input  logic [CW-1:0] mid_level,
    input  logic [CW-1:0] min_bal_cur,
    output logic          want
);
    logic dis_ok;
    logic chg_ok;
    logic cv_block;

    always_comb begin
        dis_ok   = (spread > thr_discharge) && (hi >= mid_level);
        cv_block = mode.cv && (cur < min_bal_cur);
        chg_ok   = (spread > thr_charge) && !cv_block;
        want     = mode.dis ? dis_ok : chg_ok;
    end

endmodule

// File: rtl/cell_balance_ctrl.sv
module cell_balance_ctrl #(
    parameter int CW = 12,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sup_clear,
    input  logic          tick_1hz,
    input  logic [CW-1:0] cell_a_code,
    input  logic [CW-1:0] cell_b_code,
    input  logic [CW-1:0] chg_cur_code,
    input  logic          dis_phase,
    input  logic          cv_mode,
    input  logic [CW-1:0] thr_charge,
    input  logic [CW-1:0] thr_discharge,
    input  logic [CW-1:0] mid_level,
    input  logic [CW-1:0] min_bal_cur,
    input  logic [TW-1:0] interval_s,
    input  logic [TW-1:0] start_dly_s,
    input  logic [TW-1:0] end_dly_s,
    output logic          shunt_a,
    output logic          shunt_b,
    output logic          chg_pause,
    output logic          report_stb
);
    import cbal_pkg::*;

    cbal_state_t   state_q, state_d;
    logic          tmr_en, tmr_clr, tmr_exp;
    logic [TW-1:0] tmr_limit;

    logic [CW-1:0] cap_a_q, cap_b_q, cap_cur_q;
    cbal_mode_t    cap_mode_q;

    logic [CW-1:0] hi_w, spread_w;
    logic          a_above_w, want_w;
    logic          shunt_a_q, shunt_b_q;

    // timer source per state
    always_comb begin
        tmr_en    = 1'b0;
        tmr_limit = '0;
        unique case (state_q)
            ST_IDLE:   begin tmr_en = 1'b1; tmr_limit = interval_s;  end
            ST_SETTLE: begin tmr_en = 1'b1; tmr_limit = start_dly_s; end
            ST_HOLD:   begin tmr_en = 1'b1; tmr_limit = end_dly_s;   end
            ST_EVAL, ST_REPORT: begin tmr_en = 1'b0; tmr_limit = '0; end
            default:   begin tmr_en = 1'b0; tmr_limit = '0; end
        endcase
    end

    assign tmr_clr = sup_clear || (state_d != state_q);

    cbal_tick_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .en     (tmr_en),
        .tick   (tick_1hz),
        .limit  (tmr_limit),
        .expire (tmr_exp)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (sup_clear) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (tmr_exp) state_d = ST_SETTLE;
                ST_SETTLE: if (tmr_exp) state_d = ST_EVAL;
                ST_EVAL:   state_d = ST_REPORT;
                ST_REPORT: state_d = ST_HOLD;
                ST_HOLD:   if (tmr_exp) state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // capture of the measurement at the end of settling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a_q    <= '0;
            cap_b_q    <= '0;
            cap_cur_q  <= '0;
            cap_mode_q <= '0;
        end else if (state_q == ST_SETTLE && tmr_exp && !sup_clear) begin
            cap_a_q        <= cell_a_code;
            cap_b_q        <= cell_b_code;
            cap_cur_q      <= chg_cur_code;
            cap_mode_q.dis <= dis_phase;
            cap_mode_q.cv  <= cv_mode;
        end
    end

    cbal_spread #(.CW(CW)) u_spread (
        .code_a  (cap_a_q),
        .code_b  (cap_b_q),
        .hi      (hi_w),
        .spread  (spread_w),
        .a_above (a_above_w)
    );

    cbal_judge #(.CW(CW)) u_judge (
        .mode          (cap_mode_q),
        .hi            (hi_w),
        .spread        (spread_w),
        .cur           (cap_cur_q),
        .thr_charge    (thr_charge),
        .thr_discharge (thr_discharge),
        .mid_level     (mid_level),
        .min_bal_cur   (min_bal_cur),
        .want          (want_w)
    );

    // shunt registers
    always_ff @(posedge clk) begin
        if (!rst_n || sup_clear) begin
            shunt_a_q <= 1'b0;
            shunt_b_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_EVAL: begin
                    shunt_a_q <= want_w && a_above_w;
                    shunt_b_q <= want_w && !a_above_w;
                end
                ST_HOLD: if (tmr_exp) begin
                    shunt_a_q <= 1'b0;
                    shunt_b_q <= 1'b0;
                end
                ST_REPORT: ;
                ST_IDLE, ST_SETTLE: begin
                    shunt_a_q <= 1'b0;
                    shunt_b_q <= 1'b0;
                end
                default: begin
                    shunt_a_q <= 1'b0;
                    shunt_b_q <= 1'b0;
                end
            endcase
        end
    end

    // output decode
    always_comb begin
        chg_pause  = 1'b0;
        report_stb = 1'b0;
        unique case (state_q)
            ST_IDLE:   chg_pause = 1'b0;
            ST_SETTLE: chg_pause = 1'b1;
            ST_EVAL:   chg_pause = 1'b1;
            ST_REPORT: begin
                chg_pause  = cap_mode_q.dis;
                report_stb = 1'b1;
            end
            ST_HOLD:   chg_pause = cap_mode_q.dis;
            default:   chg_pause = 1'b0;
        endcase
    end

    assign shunt_a = shunt_a_q;
    assign shunt_b = shunt_b_q;

    // assertions
    p_shunt_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(shunt_a && shunt_b));

    p_clear_opens_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sup_clear |=> (!shunt_a && !shunt_b && !chg_pause));

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        report_stb |=> !report_stb);

    p_shunt_with_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shunt_a || shunt_b) |-> report_stb);

    p_pass_opens_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_pause) |-> (!shunt_a && !shunt_b));

    p_capture_then_report_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && !sup_clear) |=> report_stb);

endmodule

// File: tb/cell_balance_ctrl_tb.sv
`timescale 1ns/1ps
module cell_balance_ctrl_tb;
    localparam int CW = 12;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sup_clear = 1'b0;
    logic          tick_1hz = 1'b0;
    logic [CW-1:0] cell_a_code = '0, cell_b_code = '0, chg_cur_code = '0;
    logic          dis_phase = 1'b0, cv_mode = 1'b0;
    logic [CW-1:0] thr_charge = '0, thr_discharge = '0, mid_level = '0, min_bal_cur = '0;
    logic [TW-1:0] interval_s = '0, start_dly_s = '0, end_dly_s = '0;
    logic          shunt_a, shunt_b, chg_pause, report_stb;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cell_balance_ctrl #(.CW(CW), .TW(TW)) u_dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick_1hz = 1'b1;
        @(negedge clk) tick_1hz = 1'b0;
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // expected shunts: bit0 = A, bit1 = B
    function automatic int exp_shunt(input int a, input int b, input int cur, input bit dis,
                                     input bit cv, input int thc, input int thd,
                                     input int mid, input int minc);
        int mx, mn, d;
        bit req;
        mx = (a > b) ? a : b;
        mn = (a > b) ? b : a;
        d = mx - mn;
        if (dis) req = (d > thd) && (mx >= mid);
        else     req = (d > thc) && !(cv && (cur < minc));
        if (!req) return 0;
        return (a > b) ? 1 : 2;
    endfunction

    task automatic run_pass(input int a, input int b, input int cur, input bit dis, input bit cv,
                            input bit clear_in_hold);
        int e, sh, ni, ns, ne;
        @(negedge clk);
        cell_a_code = CW'(a); cell_b_code = CW'(b); chg_cur_code = CW'(cur);
        dis_phase = dis; cv_mode = cv;
        e = exp_shunt(a, b, cur, dis, cv, int'(thr_charge), int'(thr_discharge),
                      int'(mid_level), int'(min_bal_cur));
        ni = eff(int'(interval_s)); ns = eff(int'(start_dly_s)); ne = eff(int'(end_dly_s));
        for (int k = 1; k <= ni; k++) begin
            if (k == ni) chk(chg_pause == 1'b0, "R2 pause early", chg_pause, 0);
            pulse_tick();
        end
        chk(chg_pause == 1'b1, (interval_s == 0) ? "R2/R12 pause" : "R2 pause", chg_pause, 1);
        chk({shunt_b, shunt_a} == 2'b00, "R2 shunts open", {shunt_b, shunt_a}, 0);
        for (int k = 1; k <= ns; k++) pulse_tick();
        chk(chg_pause == 1'b1 && report_stb == 1'b0, (start_dly_s == 0) ? "R3/R12 eval" : "R3 eval",
            {report_stb, chg_pause}, 1);
        @(negedge clk);
        sh = {shunt_b, shunt_a};
        chk(report_stb == 1'b1, "R8 strobe", report_stb, 1);
        chk(sh == e, dis ? "R4 discharge decision" : "R5 charge decision", sh, e);
        if (e != 0) chk(sh == e, "R6 cell choice", sh, e);
        chk(sh != 3, "R11 exclusive", sh, e);
        chk(chg_pause == dis, "R7 pause at report", chg_pause, dis);
        @(negedge clk);
        if (clear_in_hold) begin
            sup_clear = 1'b1;
            @(negedge clk) sup_clear = 1'b0;
            chk({shunt_b, shunt_a, chg_pause} == 3'b000, "R10 clear",
                {shunt_b, shunt_a, chg_pause}, 0);
            return;
        end
        chk(report_stb == 1'b0, "R8 strobe single", report_stb, 0);
        chk({shunt_b, shunt_a} == e, "R9 hold", {shunt_b, shunt_a}, e);
        chk(chg_pause == dis, "R7 pause in hold", chg_pause, dis);
        for (int k = 1; k <= ne; k++) begin
            if (k == ne) chk({shunt_b, shunt_a} == e, "R9 before end", {shunt_b, shunt_a}, e);
            pulse_tick();
        end
        chk({shunt_b, shunt_a, chg_pause} == 3'b000,
            (end_dly_s == 0) ? "R9/R12 end" : "R9 end", {shunt_b, shunt_a, chg_pause}, 0);
    endtask

    initial begin
        int a, b, d;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk({shunt_b, shunt_a, chg_pause, report_stb} == 4'b0, "R1 reset",
            {shunt_b, shunt_a, chg_pause, report_stb}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({shunt_b, shunt_a, chg_pause, report_stb} == 4'b0, "R1 idle",
            {shunt_b, shunt_a, chg_pause, report_stb}, 0);

        // directed corners
        thr_charge = 12'd40; thr_discharge = 12'd30; mid_level = 12'd3000; min_bal_cur = 12'd500;
        interval_s = 16'd3; start_dly_s = 16'd2; end_dly_s = 16'd4;
        run_pass(2500, 2450, 900, 1'b0, 1'b0, 1'b0);   // spread 50 > 40: A
        interval_s = 0; start_dly_s = 0; end_dly_s = 0;
        run_pass(2500, 2540, 900, 1'b0, 1'b0, 1'b0);   // spread equal to threshold: none
        run_pass(2400, 2600, 499, 1'b0, 1'b1, 1'b0);   // cv, current below min: none
        run_pass(2400, 2600, 500, 1'b0, 1'b1, 1'b0);   // cv, current at min: B
        run_pass(3000, 2900, 0, 1'b1, 1'b0, 1'b0);     // max at mid level: A
        run_pass(2999, 2900, 0, 1'b1, 1'b0, 1'b0);     // max below mid: none
        run_pass(2700, 2700, 900, 1'b0, 1'b0, 1'b0);   // equal cells: none
        interval_s = 16'd2;
        run_pass(2500, 2600, 900, 1'b0, 1'b0, 1'b1);   // clear during hold
        run_pass(2500, 2600, 900, 1'b1, 1'b0, 1'b0);   // after clear, full interval again

        // constrained random passes
        for (int i = 0; i < 40; i++) begin
            thr_charge    = CW'(8 + $urandom % 40);
            thr_discharge = CW'(8 + $urandom % 40);
            mid_level     = CW'(2400 + $urandom % 800);
            min_bal_cur   = CW'($urandom % 2048);
            interval_s    = TW'($urandom % 3);
            start_dly_s   = TW'($urandom % 3);
            end_dly_s     = TW'($urandom % 3);
            a = 2048 + int'($urandom % 1024);
            d = int'($urandom % 96);
            b = ($urandom % 2 == 0) ? a + d : a - d;
            run_pass(a, b, int'($urandom % 4096), 1'($urandom), 1'($urandom), 1'b0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule